// File: doc/BRIEF.md
# Edge-Latched Interrupt Request Controller

This block merges up to three interrupt sources into one level-sensitive request line for a host. The sources are bit 3 of a general-purpose port (port C), an external logic-level input and the output of a timer channel. Static configuration inputs take the place of board strapping. One picks which of the two digital candidates (port bit or external input) acts as the digital source. Two more turn the digital source and the timer source on or off.

Each source is brought into the clock domain through a synchronizer. Its rising edge is then detected. Any enabled rising edge sets a single pending latch. Software controls the block only through write strobes, and the write data is never looked at. A write to offset 0xE turns the request enable on. A write to 0xD turns it off. A write to 0xF clears the pending latch. A separate active-low hardware disable pin holds the request low whatever the other state is.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the request output is low, the software enable is off and the pending latch is clear.
- R2: With the digital source on and the select input low (`sel_ext_i`=0), a rising edge on `pc3_i` sets the pending latch.
- R3: With the digital source on and the select input high (`sel_ext_i`=1), a rising edge on `ext_i` sets the pending latch.
- R4: With the timer source on, a rising edge on `tmr_i` sets the pending latch.
- R5: An edge on a source that is gated off, or on the digital candidate that is not selected, leaves the pending latch clear.
- R6: A falling edge on any source does not set the pending latch.
- R7: A write strobe to offset 0xE sets the software enable. The request output is high exactly when the pending latch is set, the software enable is set and `hw_dis_n_i` is high.
- R8: A write strobe to offset 0xD clears the software enable. The pending latch is kept.
- R9: A write strobe to offset 0xF clears the pending latch. Write strobes to any other offset change nothing.
- R10: When a clear write and a detected edge fall in the same cycle, the pending latch ends up set.
- R11: An edge that arrives while the software enable is off still sets the pending latch. The request appears once the enable is set.
- R12: While `hw_dis_n_i` is low the request output is low. The pending state is kept and shows again when the pin returns high.
- R13: After a source input rises, the pending latch is set at the third rising clock edge, counting the first edge that samples the new level as edge one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pc3_i | input | 1 | Port C bit 3, asynchronous |
| ext_i | input | 1 | External interrupt input, asynchronous |
| tmr_i | input | 1 | Timer channel output, asynchronous |
| sel_ext_i | input | 1 | Static: 1 selects ext_i, 0 selects pc3_i as digital source |
| dig_en_i | input | 1 | Static: digital source gate |
| tmr_en_i | input | 1 | Static: timer source gate |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | ADDR_W (5) | Register write offset |
| hw_dis_n_i | input | 1 | Active-low hardware request disable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every combination of select and gate inputs against an edge on each source. A design that decoded the select backwards, or let a gated source through, would raise a request where the bench predicts none. It then drops each source after clearing. A design that triggered on levels or on both edges would show the request again. A clear write is placed in exactly the cycle where a detected edge lands, and a design that let the clear win would drop the request. The bench also checks a rise cycle by cycle, so one synchronizer stage too few or too many shows up as an early or late request. Writes to unrelated offsets, edges during disable and the hardware disable pin are checked to confirm that the pending state survives masking.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Source slots inside the synchronized edge vector
   localparam int SRC_PC3 = 0;
   localparam int SRC_EXT = 1;
   localparam int SRC_TMR = 2;
   localparam int NSRC    = 3;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_EN   = 2'd1,
      CMD_DIS  = 2'd2,
      CMD_CLR  = 2'd3
   } irq_cmd_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] sh_q;
   logic          prev_q;
   logic          synced;

   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[LAST-1:0], d_i};
         prev_q <= synced;
      end
   end

   assign synced = sh_q[LAST];
   assign rise_o = synced & ~prev_q;

   // a detected rise lasts exactly one cycle (R6: only the 0->1 step counts)
   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
   import irq_pkg::*;
#(
   parameter bit HAS_TIMER = 1'b1
) (
   input  logic [NSRC-1:0] rise_i,
   input  logic            sel_ext_i,
   input  logic            dig_en_i,
   input  logic            tmr_en_i,
   output logic            trig_o
);
   logic dig_edge;
   logic tmr_edge;

   assign dig_edge = dig_en_i & (sel_ext_i ? rise_i[SRC_EXT] : rise_i[SRC_PC3]);

   generate
      if (HAS_TIMER) begin : g_tmr
         assign tmr_edge = tmr_en_i & rise_i[SRC_TMR];
      end else begin : g_no_tmr
         logic unused_tmr;
         assign unused_tmr = tmr_en_i ^ rise_i[SRC_TMR];
         assign tmr_edge   = 1'b0;
      end
   endgenerate

   assign trig_o = dig_edge | tmr_edge;

   // R5: with every gate off no trigger may ever leave this stage
   always_comb begin
      assert_gated_off_R5: assert (!(trig_o && !dig_en_i && !tmr_en_i));
   end
endmodule

// File: rtl/irq_latch_ctl.sv
module irq_latch_ctl
   import irq_pkg::*;
#(
   parameter int          ADDR_W  = 5,
   parameter logic [ADDR_W-1:0] OFF_EN  = 'hE,
   parameter logic [ADDR_W-1:0] OFF_DIS = 'hD,
   parameter logic [ADDR_W-1:0] OFF_CLR = 'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              hw_dis_n_i,
   output logic              irq_o
);
   irq_cmd_e cmd;
   logic     en_q;
   logic     pend_q;

   always_comb begin
      cmd = CMD_NONE;
      if (wr_en_i) begin
         if (wr_addr_i == OFF_EN)       cmd = CMD_EN;
         else if (wr_addr_i == OFF_DIS) cmd = CMD_DIS;
         else if (wr_addr_i == OFF_CLR) cmd = CMD_CLR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (cmd == CMD_EN)       en_q <= 1'b1;
         else if (cmd == CMD_DIS) en_q <= 1'b0;

         if (trig_i)              pend_q <= 1'b1;
         else if (cmd == CMD_CLR) pend_q <= 1'b0;
      end
   end

   assign irq_o = pend_q & en_q & hw_dis_n_i;

   assert_edge_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> pend_q);
   assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == OFF_CLR && !trig_i) |=> !pend_q);
   assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == OFF_EN) |=> en_q);
   assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == OFF_DIS) |=> (!en_q && $stable(pend_q) || $past(trig_i)));
   assert_pend_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(trig_i));
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
   import irq_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_TIMER   = 1'b1,
   parameter int OFF_EN      = 'hE,
   parameter int OFF_DIS     = 'hD,
   parameter int OFF_CLR     = 'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc3_i,
   input  logic              ext_i,
   input  logic              tmr_i,
   input  logic              sel_ext_i,
   input  logic              dig_en_i,
   input  logic              tmr_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              hw_dis_n_i,
   output logic              irq_o
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (OFF_EN >= ADDR_SPAN || OFF_DIS >= ADDR_SPAN || OFF_CLR >= ADDR_SPAN) begin : g_chk_span
         $error("irq_edge_ctrl: an offset does not fit in ADDR_W");
      end
      if (OFF_EN == OFF_DIS || OFF_EN == OFF_CLR || OFF_DIS == OFF_CLR) begin : g_chk_uniq
         $error("irq_edge_ctrl: offsets must differ");
      end
   endgenerate

   logic [NSRC-1:0] raw;
   logic [NSRC-1:0] rise;
   logic            trig;

   assign raw[SRC_PC3] = pc3_i;
   assign raw[SRC_EXT] = ext_i;
   assign raw[SRC_TMR] = tmr_i;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         irq_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (raw[i]),
            .rise_o (rise[i])
         );
      end
   endgenerate

   irq_src_gate #(.HAS_TIMER(HAS_TIMER)) u_gate (
      .rise_i    (rise),
      .sel_ext_i (sel_ext_i),
      .dig_en_i  (dig_en_i),
      .tmr_en_i  (tmr_en_i),
      .trig_o    (trig)
   );

   irq_latch_ctl #(
      .ADDR_W  (ADDR_W),
      .OFF_EN  (ADDR_W'(OFF_EN)),
      .OFF_DIS (ADDR_W'(OFF_DIS)),
      .OFF_CLR (ADDR_W'(OFF_CLR))
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .hw_dis_n_i (hw_dis_n_i),
      .irq_o      (irq_o)
   );

   // R12: the hardware disable pin always wins
   always_comb begin
      assert_hw_mask_R12: assert (!(irq_o && !hw_dis_n_i));
   end
endmodule

// File: tb/sim_irq_edge_ctrl.sv
`timescale 1ns/1ps
module sim_irq_edge_ctrl;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pc3 = 0, ext = 0, tmr = 0;
   logic sel_ext = 0, dig_en = 0, tmr_en = 0;
   logic wr_en = 0;
   logic [AW-1:0] wr_addr = '0;
   logic hw_dis_n = 1'b1;
   logic irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_edge_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pc3_i(pc3), .ext_i(ext), .tmr_i(tmr),
      .sel_ext_i(sel_ext), .dig_en_i(dig_en), .tmr_en_i(tmr_en),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .hw_dis_n_i(hw_dis_n), .irq_o(irq)
   );

   task automatic chk(input string req, input logic exp);
      n_chk++;
      if (irq !== exp) begin
         n_bad++;
         $display("FAIL %s: irq_o=%b expected %b at %0t", req, irq, exp, $time);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0;
   endtask

   task automatic set_src(input int s, input logic v);
      case (s)
         0: pc3 = v;
         1: ext = v;
         default: tmr = v;
      endcase
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      wr(5'hE);
      chk("R1 pending clear after reset", 1'b0);

      // sweep configuration x source
      for (int cfg = 0; cfg < 8; cfg++) begin
         for (int s = 0; s < 3; s++) begin
            logic exp;
            sel_ext = cfg[0]; dig_en = cfg[1]; tmr_en = cfg[2];
            exp = (s == 0 && dig_en && !sel_ext) ||
                  (s == 1 && dig_en &&  sel_ext) ||
                  (s == 2 && tmr_en);
            wr(5'hF); wr(5'hE);
            @(negedge clk); set_src(s, 1'b1);
            settle();
            chk(exp ? (s == 0 ? "R2 pc3 edge" : s == 1 ? "R3 ext edge" : "R4 timer edge")
                    : "R5 gated or unselected", exp);
            wr(5'hF);
            set_src(s, 1'b0);
            settle();
            chk("R6 falling edge ignored", 1'b0);
         end
      end

      // R13 latency, timer source
      sel_ext = 0; dig_en = 0; tmr_en = 1;
      wr(5'hF);
      @(negedge clk); tmr = 1'b1;
      @(negedge clk); chk("R13 not after edge 1", 1'b0);
      @(negedge clk); chk("R13 not after edge 2", 1'b0);
      @(negedge clk); chk("R13 set after edge 3", 1'b1);

      // other offsets change nothing
      wr(5'h3); wr(5'hC); wr(5'h1E);
      chk("R9 other offsets ignored", 1'b1);
      // disable masks, pending kept
      wr(5'hD);
      chk("R8 disable masks", 1'b0);
      wr(5'hE);
      chk("R8 pending kept over disable", 1'b1);
      // hardware disable
      @(negedge clk); hw_dis_n = 1'b0;
      #1 chk("R12 hw disable masks", 1'b0);
      @(negedge clk); hw_dis_n = 1'b1;
      #1 chk("R12 pending shows again", 1'b1);
      wr(5'hF);
      chk("R9 clear drops request", 1'b0);
      tmr = 1'b0; settle();

      // R10 clear and edge in the same cycle
      wr(5'hF);
      @(negedge clk); tmr = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_addr = 5'hF;
      @(negedge clk); wr_en = 1'b0; wr_addr = '0;
      chk("R10 edge wins over clear", 1'b1);
      wr(5'hF); tmr = 1'b0; settle();

      // R11 edge while disabled
      wr(5'hD);
      @(negedge clk); tmr = 1'b1;
      settle();
      chk("R11 masked while disabled", 1'b0);
      wr(5'hE);
      chk("R11 appears on enable", 1'b1);
      chk("R7 enable with pending", 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      done = 1;
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule